// File: doc/BRIEF.md
# Logical Barrel Shifter with Merged Mux Stages

This block shifts a data word of `WIDTH` bits (a power of two) by an amount of log2(`WIDTH`) bits. The direction is fixed when the block is built, either toward the most significant bit (left) or toward bit 0 (right). Positions that the shift empties are filled with zeros. The block is purely combinational, so the result follows the inputs with no clock.

A plain barrel shifter chains one 2:1 multiplexer stage per shift-amount bit. Here the chain is cut into groups by a build-time plan. Each group is one of three kinds:

- a single stage, built from 2:1 multiplexers;
- a merged stage on two shift bits, built from 4:1 multiplexers;
- a merged stage on three shift bits, built from 8:1 multiplexers.

The shift bits in a group can be any positions of the amount, so an integrator can place the late-arriving amount bits together in the last, shallow groups. For every valid plan the result is the same. The plan is checked during elaboration, and a faulty plan stops the build.

Top module: `merged_barrel_shifter`

## Requirements
- R1: With the left direction, `data_out[q]` equals `data_in[q - shamt]` for every q >= `shamt`.
- R2: With the right direction, `data_out[q]` equals `data_in[q + shamt]` for every q with q + `shamt` < `WIDTH`.
- R3: Every output position with no source bit is 0. For a left shift these are the lowest `shamt` bits; for a right shift they are the highest `shamt` bits.
- R4: A shift amount of 0 gives `data_out` equal to `data_in`.
- R5: The largest amount, `WIDTH`-1, keeps exactly one input bit. A left shift moves `data_in[0]` to the top bit. A right shift moves `data_in[WIDTH-1]` to bit 0. Every other output bit is 0.
- R6: For the same data, amount and direction, the output is identical under every valid plan. This covers a plan of all single stages and plans that mix merged groups.
- R7: A merged group of two or three bits gives correct results when its shift bits are not adjacent in the amount (for example bits 0, 2 and 3 in one 8:1 group).
- R8: The plan is given in two parameters. `GROUP_SIZES` holds 2-bit fields, with group 0 in bits [1:0]. `BIT_ORDER` holds 8-bit amount-bit indices, with position 0 in bits [7:0]. The groups take positions from `BIT_ORDER` in order, starting with group 0. The check `shm_pkg::plan_ok` returns 1 only in this case: every size lies in 1..3, the sizes add up to log2(`WIDTH`), and every amount bit appears exactly once. In any other case it returns 0 and elaboration stops.
- R9: The output is a combinational function of the present inputs, with no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_in | input | WIDTH | Word to be shifted |
| shamt | input | log2(WIDTH) | Shift amount |
| data_out | output | WIDTH | Shifted word, zero-filled |

## Verification
All results are due in the same cycle as the stimulus, because no register lies on any path (R9). The bench drives a new data word and amount just after a rising edge. It samples all six shifter builds at the next falling edge, half a period later. Every sample is compared with a behavioural reference shift, so the check never waits on a later edge. The bench tests every amount with several random and fixed words, and it compares builds that differ only in their plan against each other.

// File: rtl/shm_pkg.sv
package shm_pkg;

   localparam int MAX_GROUPS = 16;
   localparam int MAX_BITS   = 16;

   typedef logic [2*MAX_GROUPS-1:0] size_list_t;
   typedef logic [8*MAX_BITS-1:0]   bit_list_t;

   // Size of group g, read from its 2-bit field.
   function automatic int group_size(size_list_t sizes, int g);
      return int'(sizes[2*g +: 2]);
   endfunction

   // First BIT_ORDER position used by group g.
   function automatic int group_start(size_list_t sizes, int g);
      int acc;
      acc = 0;
      for (int k = 0; k < MAX_GROUPS; k++) begin
         if (k < g) acc += int'(sizes[2*k +: 2]);
      end
      return acc;
   endfunction

   // Amount-bit index stored at position pos.
   function automatic int bit_at(bit_list_t order, int pos);
      return int'(order[8*pos +: 8]);
   endfunction

   // A plan is accepted only when it covers each amount bit exactly once.
   function automatic bit plan_ok(int nbits, int ngroups, size_list_t sizes,
                                  bit_list_t order);
      logic [MAX_BITS-1:0] seen;
      int total;
      int sz;
      int idx;
      bit ok;
      ok    = (ngroups >= 1) && (ngroups <= MAX_GROUPS) &&
              (nbits >= 1) && (nbits <= MAX_BITS);
      total = 0;
      seen  = '0;
      for (int g = 0; g < MAX_GROUPS; g++) begin
         if (g < ngroups) begin
            sz = int'(sizes[2*g +: 2]);
            if (sz == 0) ok = 1'b0;
            total += sz;
         end
      end
      if (total != nbits) ok = 1'b0;
      for (int p = 0; p < MAX_BITS; p++) begin
         if (p < nbits) begin
            idx = int'(order[8*p +: 8]);
            if (idx >= nbits)          ok = 1'b0;
            else if (seen[idx[3:0]])   ok = 1'b0;
            else                       seen[idx[3:0]] = 1'b1;
         end
      end
      return ok;
   endfunction

endpackage

// File: rtl/shm_col_select.sv
module shm_col_select #(
   parameter int SIZE = 1,
   localparam int NCAND = 1 << SIZE
) (
   input  logic [NCAND-1:0] cand,
   input  logic [SIZE-1:0]  sel,
   output logic             y
);

   generate
      if (SIZE == 1) begin : g_two
         assign y = sel[0] ? cand[1] : cand[0];
      end else if (SIZE == 2) begin : g_four
         always_comb begin
            unique case (sel)
               2'd0:    y = cand[0];
               2'd1:    y = cand[1];
               2'd2:    y = cand[2];
               default: y = cand[3];
            endcase
         end
      end else begin : g_eight
         assign y = cand[sel];
      end
   endgenerate

endmodule

// File: rtl/shm_stage.sv
module shm_stage #(
   parameter int WIDTH      = 32,
   parameter bit SHIFT_LEFT = 1'b1,
   parameter int SIZE       = 1,
   parameter int DIST0      = 1,
   parameter int DIST1      = 0,
   parameter int DIST2      = 0,
   localparam int NCAND     = 1 << SIZE
) (
   input  logic [WIDTH-1:0] din,
   input  logic [SIZE-1:0]  sel,
   output logic [WIDTH-1:0] dout
);

   initial begin
      if (SIZE < 1 || SIZE > 3) $error("shm_stage: SIZE must be 1..3");
   end

   generate
      for (genvar q = 0; q < WIDTH; q++) begin : g_col
         logic [NCAND-1:0] cand;
         for (genvar c = 0; c < NCAND; c++) begin : g_cand
            localparam int OFF = (((c & 1) != 0) ? DIST0 : 0) +
                                 (((c & 2) != 0) ? DIST1 : 0) +
                                 (((c & 4) != 0) ? DIST2 : 0);
            localparam int SRC = SHIFT_LEFT ? (q - OFF) : (q + OFF);
            if (SRC >= 0 && SRC < WIDTH) begin : g_src
               assign cand[c] = din[SRC];
            end else begin : g_zero
               assign cand[c] = 1'b0;
            end
         end
         shm_col_select #(.SIZE(SIZE)) u_sel (
            .cand (cand),
            .sel  (sel),
            .y    (dout[q])
         );
      end
   endgenerate

endmodule

// File: rtl/merged_barrel_shifter.sv
module merged_barrel_shifter #(
   parameter int WIDTH      = 32,
   parameter bit SHIFT_LEFT = 1'b1,
   parameter int NUM_GROUPS = 2,
   parameter logic [2*NUM_GROUPS-1:0]     GROUP_SIZES = 4'b10_11,
   parameter logic [8*$clog2(WIDTH)-1:0]  BIT_ORDER   = {8'd3, 8'd0, 8'd2, 8'd1, 8'd4}
) (
   input  logic [WIDTH-1:0]         data_in,
   input  logic [$clog2(WIDTH)-1:0] shamt,
   output logic [WIDTH-1:0]         data_out
);

   localparam int LOG2W = $clog2(WIDTH);
   localparam shm_pkg::size_list_t SIZES_EXT = shm_pkg::size_list_t'(GROUP_SIZES);
   localparam shm_pkg::bit_list_t  ORDER_EXT = shm_pkg::bit_list_t'(BIT_ORDER);
   localparam bit PLAN_OK = shm_pkg::plan_ok(LOG2W, NUM_GROUPS, SIZES_EXT, ORDER_EXT);
   localparam bit WIDTH_OK = (WIDTH >= 2) && ((1 << LOG2W) == WIDTH) &&
                             (LOG2W <= shm_pkg::MAX_BITS);

   generate
      if (!WIDTH_OK) begin : g_bad_width
         $error("merged_barrel_shifter: WIDTH must be a power of two");
      end
      if (!PLAN_OK) begin : g_bad_plan
         $error("merged_barrel_shifter: grouping plan does not cover each bit once");
      end
   endgenerate

   logic [WIDTH-1:0] chain [NUM_GROUPS+1];
   assign chain[0] = data_in;

   generate
      for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
         localparam int SZ_RAW = shm_pkg::group_size(SIZES_EXT, g);
         localparam int SZ     = (SZ_RAW < 1) ? 1 : SZ_RAW;
         localparam int START  = shm_pkg::group_start(SIZES_EXT, g);
         localparam int B0_RAW = shm_pkg::bit_at(ORDER_EXT, START);
         localparam int B1_RAW = (SZ > 1) ? shm_pkg::bit_at(ORDER_EXT, START + 1) : 0;
         localparam int B2_RAW = (SZ > 2) ? shm_pkg::bit_at(ORDER_EXT, START + 2) : 0;
         localparam int B0 = (B0_RAW < LOG2W) ? B0_RAW : 0;
         localparam int B1 = (B1_RAW < LOG2W) ? B1_RAW : 0;
         localparam int B2 = (B2_RAW < LOG2W) ? B2_RAW : 0;

         logic [SZ-1:0] sel;
         assign sel[0] = shamt[B0];
         if (SZ > 1) begin : g_s1
            assign sel[1] = shamt[B1];
         end
         if (SZ > 2) begin : g_s2
            assign sel[2] = shamt[B2];
         end

         shm_stage #(
            .WIDTH      (WIDTH),
            .SHIFT_LEFT (SHIFT_LEFT),
            .SIZE       (SZ),
            .DIST0      (1 << B0),
            .DIST1      ((SZ > 1) ? (1 << B1) : 0),
            .DIST2      ((SZ > 2) ? (1 << B2) : 0)
         ) u_stage (
            .din  (chain[g]),
            .sel  (sel),
            .dout (chain[g+1])
         );
      end
   endgenerate

   assign data_out = chain[NUM_GROUPS];

endmodule

// File: rtl/shm_checker.sv
module shm_checker #(
   parameter int WIDTH      = 32,
   parameter bit SHIFT_LEFT = 1'b1
) (
   input logic [WIDTH-1:0]         data_in,
   input logic [$clog2(WIDTH)-1:0] shamt,
   input logic [WIDTH-1:0]         data_out
);

   localparam int LOG2W = $clog2(WIDTH);
   localparam logic [LOG2W-1:0] AMT_MAX = LOG2W'(WIDTH - 1);

   logic [WIDTH-1:0] vacant;
   logic [WIDTH-1:0] moved;

   generate
      if (SHIFT_LEFT) begin : g_left
         always_comb begin
            vacant = ~({WIDTH{1'b1}} << shamt);
            moved  = data_in << shamt;
            assert_left_shift_R1: assert (data_out == moved)
               else $error("left shift result mismatch");
            assert_max_amount_R5: assert (shamt != AMT_MAX ||
                                          data_out == {data_in[0], {(WIDTH-1){1'b0}}})
               else $error("largest left amount mismatch");
         end
      end else begin : g_right
         always_comb begin
            vacant = ~({WIDTH{1'b1}} >> shamt);
            moved  = data_in >> shamt;
            assert_right_shift_R2: assert (data_out == moved)
               else $error("right shift result mismatch");
            assert_max_amount_R5: assert (shamt != AMT_MAX ||
                                          data_out == {{(WIDTH-1){1'b0}}, data_in[WIDTH-1]})
               else $error("largest right amount mismatch");
         end
      end
   endgenerate

   always_comb begin
      assert_zero_fill_R3: assert ((data_out & vacant) == '0)
         else $error("vacated position not zero");
      assert_identity_R4: assert (shamt != '0 || data_out == data_in)
         else $error("zero amount changed the data");
      assert_ones_bound_R3: assert ($countones(data_out) <= $countones(data_in))
         else $error("shift created set bits");
   end

endmodule

bind merged_barrel_shifter shm_checker #(
   .WIDTH      (WIDTH),
   .SHIFT_LEFT (SHIFT_LEFT)
) u_chk (
   .data_in  (data_in),
   .shamt    (shamt),
   .data_out (data_out)
);

// File: tb/sim_merged_barrel_shifter.sv
`timescale 1ns/1ps
module sim_merged_barrel_shifter;

   localparam real HALF = 10.0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] din = '0;
   logic [4:0]  amt = '0;
   logic [31:0] o0, o1, o2, o5;
   logic [15:0] o3, o4;
   int          ntests = 0;
   int          nfail = 0;
   bit          done = 1'b0;

   always #(HALF) clk = ~clk;

   // default plan: triple {4,1,2}, dual {0,3}, left
   merged_barrel_shifter u0 (.data_in(din), .shamt(amt), .data_out(o0));

   // 32-bit left, all single stages
   merged_barrel_shifter #(
      .WIDTH(32), .SHIFT_LEFT(1'b1), .NUM_GROUPS(5),
      .GROUP_SIZES(10'b01_01_01_01_01),
      .BIT_ORDER({8'd4, 8'd3, 8'd2, 8'd1, 8'd0})
   ) u1 (.data_in(din), .shamt(amt), .data_out(o1));

   // 32-bit right: dual {1,4}, dual {0,2}, single {3}
   merged_barrel_shifter #(
      .WIDTH(32), .SHIFT_LEFT(1'b0), .NUM_GROUPS(3),
      .GROUP_SIZES(6'b01_10_10),
      .BIT_ORDER({8'd3, 8'd2, 8'd0, 8'd4, 8'd1})
   ) u2 (.data_in(din), .shamt(amt), .data_out(o2));

   // 16-bit left: dual {3,0}, single {1}, single {2}
   merged_barrel_shifter #(
      .WIDTH(16), .SHIFT_LEFT(1'b1), .NUM_GROUPS(3),
      .GROUP_SIZES(6'b01_01_10),
      .BIT_ORDER({8'd2, 8'd1, 8'd0, 8'd3})
   ) u3 (.data_in(din[15:0]), .shamt(amt[3:0]), .data_out(o3));

   // 16-bit right: triple {0,2,3}, single {1}
   merged_barrel_shifter #(
      .WIDTH(16), .SHIFT_LEFT(1'b0), .NUM_GROUPS(2),
      .GROUP_SIZES(4'b01_11),
      .BIT_ORDER({8'd1, 8'd3, 8'd2, 8'd0})
   ) u4 (.data_in(din[15:0]), .shamt(amt[3:0]), .data_out(o4));

   // 32-bit right, all single stages
   merged_barrel_shifter #(
      .WIDTH(32), .SHIFT_LEFT(1'b0), .NUM_GROUPS(5),
      .GROUP_SIZES(10'b01_01_01_01_01),
      .BIT_ORDER({8'd4, 8'd3, 8'd2, 8'd1, 8'd0})
   ) u5 (.data_in(din), .shamt(amt), .data_out(o5));

   function automatic logic [31:0] ref_shift(logic [31:0] d, int w, int a, bit left);
      logic [31:0] r;
      int src;
      r = '0;
      for (int q = 0; q < w; q++) begin
         src = left ? q - a : q + a;
         if (src >= 0 && src < w) r[q] = d[src];
      end
      return r;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      ntests++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h (din=%h amt=%0d)", req, act, exp, din, amt);
      end
   endtask

   task automatic apply(logic [31:0] d, logic [4:0] a);
      logic [31:0] vac;
      int a16;
      @(posedge clk);
      din = d;
      amt = a;
      @(negedge clk);
      a16 = int'(a[3:0]);
      // results are combinational: due half a cycle after the change (R9)
      chk("R1", o0, ref_shift(d, 32, int'(a), 1'b1));
      chk("R1", o1, ref_shift(d, 32, int'(a), 1'b1));
      chk("R1", {16'h0, o3}, ref_shift({16'h0, d[15:0]}, 16, a16, 1'b1));
      chk("R2", o2, ref_shift(d, 32, int'(a), 1'b0));
      chk("R2", o5, ref_shift(d, 32, int'(a), 1'b0));
      chk("R7", {16'h0, o4}, ref_shift({16'h0, d[15:0]}, 16, a16, 1'b0));
      chk("R6", o0, o1);
      chk("R6", o2, o5);
      vac = '0;
      for (int q = 0; q < 32; q++) if (q < int'(a)) vac[q] = 1'b1;
      chk("R3", o0 & vac, 32'h0);
      vac = '0;
      for (int q = 0; q < 32; q++) if (q >= 32 - int'(a)) vac[q] = 1'b1;
      chk("R3", o2 & vac, 32'h0);
      if (a == 5'd0) begin
         chk("R4", o0, d);
         chk("R4", o2, d);
      end
      if (a == 5'd31) begin
         chk("R5", o0, {d[0], 31'h0});
         chk("R5", o5, {31'h0, d[31]});
      end
      if (a[3:0] == 4'd15) begin
         chk("R5", {16'h0, o3}, {16'h0, d[0], 15'h0});
         chk("R7", {16'h0, o4}, {16'h0, 15'h0, d[15]});
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R4", o0, 32'h0);
      chk("R4", o5, 32'h0);

      // R8: plan validation
      chk("R8", 32'(shm_pkg::plan_ok(5, 2, shm_pkg::size_list_t'(4'b10_11),
            shm_pkg::bit_list_t'({8'd3, 8'd0, 8'd2, 8'd1, 8'd4}))), 32'd1);
      chk("R8", 32'(shm_pkg::plan_ok(5, 2, shm_pkg::size_list_t'(4'b10_11),
            shm_pkg::bit_list_t'({8'd4, 8'd4, 8'd2, 8'd1, 8'd0}))), 32'd0);
      chk("R8", 32'(shm_pkg::plan_ok(5, 2, shm_pkg::size_list_t'(4'b01_11),
            shm_pkg::bit_list_t'({8'd3, 8'd0, 8'd2, 8'd1, 8'd4}))), 32'd0);
      chk("R8", 32'(shm_pkg::plan_ok(4, 3, shm_pkg::size_list_t'(6'b00_10_10),
            shm_pkg::bit_list_t'({8'd3, 8'd2, 8'd1, 8'd0}))), 32'd0);
      chk("R8", 32'(shm_pkg::plan_ok(4, 2, shm_pkg::size_list_t'(4'b01_11),
            shm_pkg::bit_list_t'({8'd1, 8'd7, 8'd2, 8'd0}))), 32'd0);

      for (int a = 0; a < 32; a++) begin
         apply(32'hFFFF_FFFF, 5'(a));
         apply(32'h8000_0001, 5'(a));
         apply(32'hA5C3_3C5A, 5'(a));
         for (int k = 0; k < 5; k++) apply($urandom(), 5'(a));
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
   end

   initial begin
      #(2.0 * HALF * 200000.0);
      if (!done) begin
         ntests++;
         nfail++;
         $display("FAIL watchdog: run did not complete");
         $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
         $finish;
      end
   end

endmodule